// File: doc/BRIEF.md
# Buffer Descriptor Chain Walker

The walker follows a chain of descriptor directories kept in system memory and turns every buffer entry it meets into an (address, length) pair for a downstream consumer. It fetches memory through a one-word read port, one read outstanding at a time. Each directory entry is two 32-bit words. The first word holds the type and size. The second word holds an address.

A buffer entry is handed over on a valid/ready handshake, and the walk then moves to the next entry of the same directory. A link entry sends the walk to another directory and produces no output. A link entry whose address is zero ends the walk without error. A link entry with its reserved top bit set ends the walk with a sticky error. Software loads a start address with a one-cycle start pulse. A busy output stays high until the walk halts.

Top module: `desc_walker`

## Requirements
- R1: A start pulse while idle loads the start address, clears the error flag and raises busy on the next cycle. The first read is issued at the start address.
- R2: For an entry at address A, the attribute word is read at A and then the address word at A+4. After a buffer entry has been handed over, the next entry is read at A+8.
- R3: Attribute bit 30 = 1 marks a buffer entry. Its output address is the address word, and its output length is attribute bits 15:0, where the value 0 means 65536 bytes.
- R4: Attribute bit 30 = 0 marks a link entry. If bit 31 is 0 and the address word is nonzero, the walk continues at that address and no output is produced.
- R5: A link entry with bit 31 = 1 sets the error flag, drops busy and stops all reads. The error flag holds until the next accepted start.
- R6: A link entry with bit 31 = 0 and address word 0 ends the walk, with busy low and the error flag low.
- R7: At most one read is outstanding. No new request is issued until the response to the previous one has arrived.
- R8: While the output is valid and not ready, valid stays high and the address and length stay stable.
- R9: A start pulse while busy is ignored.
- R10: While not busy, no read request and no output valid are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| startPulse | input | 1 | begin (or restart) a walk |
| startAddr | input | AW | address of the first entry |
| busy | output | 1 | walk in progress |
| errFlag | output | 1 | sticky malformed-link error |
| reqValid | output | 1 | one-cycle read request |
| reqAddr | output | AW | read word address (byte address) |
| rspValid | input | 1 | read data returned |
| rspData | input | 32 | read data |
| bufValid | output | 1 | buffer pair offered |
| bufReady | input | 1 | consumer accepts pair |
| bufAddr | output | AW | buffer start address |
| bufLen | output | SIZE_W+1 | buffer length in bytes |

## Verification
Two events can coincide with a hand-over. The consumer's ready can arrive in the same cycle that valid first rises, and the walker's next-entry step then coincides with the hand-over. A start pulse can also arrive while a hand-over is pending. The bench provokes the first case with a pseudo-random ready pattern swept against several memory latencies. It judges the result by the exact order of read addresses and delivered pairs. It provokes the second case by pulsing start mid-walk and checks that the output stream and the read sequence are unchanged.

// File: rtl/dw_pkg.sv
package dw_pkg;
  localparam int TYPE_BIT = 30;
  localparam int RSV_BIT  = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ_ATTR, S_WAIT_ATTR, S_REQ_ADDR, S_WAIT_ADDR, S_EMIT
  } dwState_t;

  typedef struct packed {
    logic loadStart;
    logic latchAttr;
    logic latchBuf;
    logic followLink;
    logic stepNext;
    logic hiWord;
  } dwStrobes_t;
endpackage

// File: rtl/dw_datapath.sv
module dw_datapath import dw_pkg::*; #(
  parameter int AW     = 32,
  parameter int SIZE_W = 16,
  localparam int LEN_W = SIZE_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dwStrobes_t       strb,
  input  logic [AW-1:0]    startAddr,
  input  logic [31:0]      rspData,
  output logic             attrIsBuf,
  output logic             attrBad,
  output logic             rspNull,
  output logic [AW-1:0]    reqAddr,
  output logic [AW-1:0]    bufAddr,
  output logic [LEN_W-1:0] bufLen
);
  localparam logic [AW-1:0] HI_OFS   = AW'(4);
  localparam logic [AW-1:0] STEP_OFS = AW'(8);

  logic [AW-1:0]     curAddr;
  logic [SIZE_W-1:0] sizeR;
  logic              isBufR, badR;
  logic [AW-1:0]     bufAddrR;
  logic              unusedAttr;

  assign unusedAttr = ^rspData[TYPE_BIT-1:SIZE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      sizeR    <= '0;
      isBufR   <= 1'b0;
      badR     <= 1'b0;
      bufAddrR <= '0;
    end else begin
      if (strb.loadStart)  curAddr <= startAddr;
      if (strb.followLink) curAddr <= rspData[AW-1:0];
      if (strb.stepNext)   curAddr <= curAddr + STEP_OFS;
      if (strb.latchAttr) begin
        sizeR  <= rspData[SIZE_W-1:0];
        isBufR <= rspData[TYPE_BIT];
        badR   <= rspData[RSV_BIT];
      end
      if (strb.latchBuf) bufAddrR <= rspData[AW-1:0];
    end
  end

  assign attrIsBuf = isBufR;
  assign attrBad   = badR;
  assign rspNull   = (rspData[AW-1:0] == '0);
  assign reqAddr   = curAddr + (strb.hiWord ? HI_OFS : '0);
  assign bufAddr   = bufAddrR;
  assign bufLen    = (sizeR == '0) ? (LEN_W'(1) << SIZE_W) : LEN_W'(sizeR);
endmodule

// File: rtl/dw_ctrl.sv
module dw_ctrl import dw_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       rspValid,
  input  logic       bufReady,
  input  logic       attrIsBuf,
  input  logic       attrBad,
  input  logic       rspNull,
  output dwStrobes_t strb,
  output logic       reqValid,
  output logic       bufValid,
  output logic       busy,
  output logic       errFlag
);
  dwState_t state, nextState;
  logic     errR, setErr;

  always_comb begin
    nextState = state;
    strb      = '0;
    setErr    = 1'b0;
    case (state)
      S_IDLE: if (startPulse) begin
        strb.loadStart = 1'b1;
        nextState      = S_REQ_ATTR;
      end
      S_REQ_ATTR:  nextState = S_WAIT_ATTR;
      S_WAIT_ATTR: if (rspValid) begin
        strb.latchAttr = 1'b1;
        nextState      = S_REQ_ADDR;
      end
      S_REQ_ADDR: begin
        strb.hiWord = 1'b1;
        nextState   = S_WAIT_ADDR;
      end
      S_WAIT_ADDR: if (rspValid) begin
        if (attrIsBuf) begin
          strb.latchBuf = 1'b1;
          nextState     = S_EMIT;
        end else if (attrBad) begin
          setErr    = 1'b1;
          nextState = S_IDLE;
        end else if (rspNull) begin
          nextState = S_IDLE;
        end else begin
          strb.followLink = 1'b1;
          nextState       = S_REQ_ATTR;
        end
      end
      S_EMIT: if (bufReady) begin
        strb.stepNext = 1'b1;
        nextState     = S_REQ_ATTR;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      errR  <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.loadStart) errR <= 1'b0;
      else if (setErr)    errR <= 1'b1;
    end
  end

  assign reqValid = (state == S_REQ_ATTR) || (state == S_REQ_ADDR);
  assign bufValid = (state == S_EMIT);
  assign busy     = (state != S_IDLE);
  assign errFlag  = errR;
endmodule

// File: rtl/desc_walker.sv
module desc_walker import dw_pkg::*; #(
  parameter int AW     = 32,
  parameter int SIZE_W = 16,
  localparam int LEN_W = SIZE_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [AW-1:0]    startAddr,
  output logic             busy,
  output logic             errFlag,
  output logic             reqValid,
  output logic [AW-1:0]    reqAddr,
  input  logic             rspValid,
  input  logic [31:0]      rspData,
  output logic             bufValid,
  input  logic             bufReady,
  output logic [AW-1:0]    bufAddr,
  output logic [LEN_W-1:0] bufLen
);
  dwStrobes_t strb;
  logic       attrIsBuf, attrBad, rspNull;

  dw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .rspValid(rspValid),
    .bufReady(bufReady), .attrIsBuf(attrIsBuf), .attrBad(attrBad),
    .rspNull(rspNull), .strb(strb), .reqValid(reqValid),
    .bufValid(bufValid), .busy(busy), .errFlag(errFlag)
  );

  dw_datapath #(.AW(AW), .SIZE_W(SIZE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .rspData(rspData), .attrIsBuf(attrIsBuf), .attrBad(attrBad),
    .rspNull(rspNull), .reqAddr(reqAddr), .bufAddr(bufAddr), .bufLen(bufLen)
  );
endmodule

// File: rtl/dw_checker.sv
module dw_checker #(
  parameter int AW     = 32,
  parameter int SIZE_W = 16,
  localparam int LEN_W = SIZE_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             busy,
  input logic             errFlag,
  input logic             reqValid,
  input logic             rspValid,
  input logic             bufValid,
  input logic             bufReady,
  input logic [AW-1:0]    bufAddr,
  input logic [LEN_W-1:0] bufLen
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1) << SIZE_W;
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rstN)         outstanding <= 1'b0;
    else if (reqValid) outstanding <= 1'b1;
    else if (rspValid) outstanding <= 1'b0;
  end

  p_single_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !outstanding);
  p_hold_offer_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bufValid && !bufReady) |=> (bufValid && $stable(bufAddr) && $stable(bufLen)));
  p_len_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    bufValid |-> (bufLen != '0 && bufLen <= MAX_LEN));
  p_err_halts_r5: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !busy);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!reqValid && !bufValid));
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy) |=> (busy && !errFlag));
endmodule

bind desc_walker dw_checker #(.AW(AW), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .busy(busy),
  .errFlag(errFlag), .reqValid(reqValid), .rspValid(rspValid),
  .bufValid(bufValid), .bufReady(bufReady), .bufAddr(bufAddr), .bufLen(bufLen)
);

// File: tb/desc_walker_bench.sv
module desc_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SIZE_W = 16;
  localparam int LEN_W = SIZE_W + 1;

  logic clk = 0, rstN = 0, startPulse = 0;
  logic [AW-1:0] startAddr = '0;
  logic busy, errFlag, reqValid, rspValid, bufValid, bufReady;
  logic [AW-1:0] reqAddr, bufAddr;
  logic [31:0] rspData;
  logic [LEN_W-1:0] bufLen;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_walker #(.AW(AW), .SIZE_W(SIZE_W)) u_desc_walker (.*);

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [0:255];
  logic [AW-1:0] expAddr [0:63];
  int expLen [0:63];
  int nExp, gotIdx;
  logic [AW-1:0] rdExp [0:191];
  int nRd, rdIdx;
  int lat = 1, pendCnt = 0;
  logic [AW-1:0] pendAddr;
  logic stallMode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic prevValid = 0, prevReady = 0;
  logic [AW-1:0] prevAddr;
  logic [LEN_W-1:0] prevLen;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: request at edge k answers after lat edges
  always @(posedge clk) begin
    rspValid <= 1'b0;
    if (pendCnt == 1) begin
      rspValid <= 1'b1;
      rspData  <= mem[pendAddr[9:2]];
    end
    if (pendCnt > 0) pendCnt <= pendCnt - 1;
    if (rstN && reqValid) begin
      chk(pendCnt == 0, "R7 read while outstanding", pendCnt, 0);
      chk(rdIdx < nRd && reqAddr == rdExp[rdIdx], "R2 read address", reqAddr, rdExp[rdIdx]);
      rdIdx    <= rdIdx + 1;
      pendAddr <= reqAddr;
      pendCnt  <= lat;
    end
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bufReady <= stallMode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (prevValid && !prevReady)
        chk(bufValid && bufAddr == prevAddr && bufLen == prevLen, "R8 offer held", bufAddr, prevAddr);
      if (!busy) chk(!reqValid && !bufValid, "R10 quiet when idle", reqValid, 0);
      if (bufValid && bufReady) begin
        chk(gotIdx < nExp && bufAddr == expAddr[gotIdx], "R3 buffer address", bufAddr, expAddr[gotIdx]);
        chk(gotIdx < nExp && int'(bufLen) == expLen[gotIdx], "R3 buffer length", bufLen, expLen[gotIdx]);
        gotIdx++;
      end
    end
    prevValid = bufValid; prevReady = bufReady; prevAddr = bufAddr; prevLen = bufLen;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic clearAll();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    nExp = 0; gotIdx = 0; nRd = 0; rdIdx = 0;
  endtask

  // R3: bit30=1, size in bits 15:0 (0 means 65536)
  task automatic addBuf(input int a, input int size, input int ba);
    mem[a/4] = 32'h4000_0000 | (size & 32'hFFFF);
    mem[a/4 + 1] = ba;
    rdExp[nRd] = a; rdExp[nRd+1] = a + 4; nRd += 2;
    expAddr[nExp] = ba;
    expLen[nExp]  = ((size & 32'hFFFF) == 0) ? 65536 : (size & 32'hFFFF);
    nExp++;
  endtask

  // R4/R5/R6: bit30=0, bit31 reserved, address word = next directory or 0
  task automatic addLink(input int a, input int target, input logic bad);
    mem[a/4] = bad ? 32'h8000_0000 : 32'h0;
    mem[a/4 + 1] = target;
    rdExp[nRd] = a; rdExp[nRd+1] = a + 4; nRd += 2;
  endtask

  task automatic pulseStart(input int a);
    @(posedge clk); #1;
    startAddr = a; startPulse = 1;
    @(posedge clk); #1;
    startPulse = 0;
  endtask

  task automatic runWalk(input int a, input logic expErr, input string tag);
    pulseStart(a);
    chk(busy == 1'b1, {"R1 busy after start ", tag}, busy, 1);
    for (int t = 0; t < 20000 && busy; t++) @(negedge clk);
    chk(gotIdx == nExp, {"R3 output count ", tag}, gotIdx, nExp);
    chk(rdIdx == nRd, {"R2 read count ", tag}, rdIdx, nRd);
    chk(errFlag == expErr, {"R5/R6 error flag ", tag}, errFlag, expErr);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !errFlag && !reqValid && !bufValid, "R10 reset state", busy, 0);
    rstN = 1;

    // straight directory ending with null link (R2 R3 R6)
    clearAll();
    addBuf(16, 1, 32'h1000); addBuf(24, 16'h40, 32'h2000); addBuf(32, 0, 32'h3000);
    addLink(40, 0, 1'b0);
    runWalk(16, 1'b0, "straight");

    // two directories joined by a link (R4), stalled consumer (R8)
    clearAll(); lat = 3; stallMode = 1;
    addBuf(64, 16'hFFFF, 32'hA000); addLink(72, 512, 1'b0);
    addBuf(512, 2, 32'hB000); addBuf(520, 16'h8000, 32'hC000); addLink(528, 0, 1'b0);
    runWalk(64, 1'b0, "linked");

    // malformed link (R5), error sticks, then restart clears it (R1)
    clearAll(); lat = 1; stallMode = 0;
    addBuf(128, 5, 32'h5000); addLink(136, 256, 1'b1);
    runWalk(128, 1'b1, "badlink");
    repeat (10) @(negedge clk);
    chk(errFlag && !busy && !reqValid, "R5 error held", errFlag, 1);
    clearAll();
    addBuf(256, 7, 32'h7000); addLink(264, 0, 1'b0);
    runWalk(256, 1'b0, "restart");

    // empty walk: first entry is a null link (R6)
    clearAll();
    addLink(300, 0, 1'b0);
    runWalk(300, 1'b0, "empty");

    // start while busy is ignored (R9)
    clearAll(); lat = 4; stallMode = 1;
    for (int k = 0; k < 6; k++) addBuf(400 + 8*k, k * 3 + 1, 32'h9000 + k * 16);
    addLink(448, 0, 1'b0);
    pulseStart(400);
    repeat (6) @(posedge clk);
    #1; startAddr = 900; startPulse = 1;
    @(posedge clk); #1; startPulse = 0;
    for (int t = 0; t < 20000 && busy; t++) @(negedge clk);
    chk(gotIdx == nExp && rdIdx == nRd, "R9 start while busy ignored", gotIdx, nExp);

    // sweep of latencies, stall modes and size encodings
    for (int l = 1; l <= 4; l++) begin
      for (int s = 0; s < 2; s++) begin
        clearAll(); lat = l; stallMode = s[0];
        for (int k = 0; k < 5; k++)
          addBuf(8*k, (k * 16411 + l * 7 + s) & 32'hFFFF, 32'h4_0000 + k * 256 + l);
        addLink(40, 600, 1'b0);
        addBuf(600, 0, 32'hF000 + l); addBuf(608, 16'hFFFF, 32'hE000);
        addLink(616, 0, 1'b0);
        runWalk(0, 1'b0, "sweep");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule